// File: doc/BRIEF.md
# Frame-Synchronised Output Enable and Reset Sequencer

This block is the timing and control spine for a bank of PWM channels. It divides the system clock by two to produce a tick enable for the duty logic, counts ticks into fixed-length frames, and marks each frame start with a one-clock pulse. It owns the tri-state drive enables of every channel. It arranges that each change to those enables, including a reset, lands exactly on a frame boundary, so a channel never puts a truncated pulse on its pin.

Channel enable and disable commands arrive on a valid/ready command port together with the data commit for that channel. Each accepted command updates that channel's pending enable flag. The flag is promoted to the active enable at the next frame start. A global output-control pin is sampled at that same instant and can blank every channel for the whole frame. Pulling `rst_n` low lets the running frame finish. At its end the block clears all flags, drops all drive enables and pulses a clear strobe that the duty registers use. It then holds the frame counter still until `rst_n` returns high. After release, every output stays off until its channel receives a new enabling command.

The command port rules are as follows. `cmd_ready_o` is low only while the sequencer is held in reset. A command counts only in a cycle where `cmd_valid_i` and `cmd_ready_o` are both high. There is no buffering, so a command offered while ready is low has no effect.

Top module: `frame_oe_sequencer`

## Requirements
- R1: While running, `tick_o` is high on every second clock, beginning with the second clock of each frame; it is low while the sequencer is held.
- R2: `frame_start_o` is a one-clock pulse repeating every 2×2^FRAME_BITS clocks while running, and is never high on a tick clock.
- R3: `oc_i` is sampled only on the frame-start clock; if it was high there, `drv_en_o` is all zeros for that whole frame, and later changes of `oc_i` within the frame have no effect.
- R4: If `oc_i` was low at the frame start, bit c of `drv_en_o` equals channel c's active enable for that frame.
- R5: An accepted command with `cmd_ch_i` = c (binary index, 0 to NCH-1) sets channel c's pending flag when `cmd_en_i` = 1 and clears it when `cmd_en_i` = 0, leaving the other channels unchanged.
- R6: A command reaches `drv_en_o` only on the clock after the next frame-start pulse; a command accepted on a frame-start clock waits for the following frame.
- R7: With `rst_n` low, the running frame completes unchanged; on the clock after its last one, `clr_o` is high for exactly one clock, `drv_en_o` is zero and all pending flags are cleared.
- R8: While held, `cmd_ready_o`, `tick_o` and `frame_start_o` are low and the frame counter stays at zero.
- R9: On the clock after the first edge that samples `rst_n` high while held, `frame_start_o` is high; all drive enables remain zero until a fresh enabling command is promoted.
- R10: `cmd_ready_o` is high whenever the sequencer is not held; a command presented with `cmd_valid_i` low, or while ready is low, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low frame-deferred reset request |
| oc_i | input | 1 | Global output blank, high blanks all channels for a frame |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command ready, low while held |
| cmd_ch_i | input | CH_W | Target channel index |
| cmd_en_i | input | 1 | 1 enables, 0 disables the target channel |
| tick_o | output | 1 | Duty-logic advance enable, half clock rate |
| frame_start_o | output | 1 | One-clock pulse on the first clock of each frame |
| drv_en_o | output | NCH | Per-channel tri-state drive enable |
| clr_o | output | 1 | One-clock strobe clearing the duty registers |

## Verification
The corner cases are the boundary instants. A command that lands on the frame-start clock must wait a full frame, and a design that forwarded it at once would show the enable one frame early. An `oc_i` change partway through a frame must not blank the outputs, and a design that used the live pin would chop the frame mid-pulse. A reset dropped partway through a frame must let the frame run to its last clock, and a design that cleared at once would emit a short final frame and an early clear strobe. After release the outputs must stay dark, and a design that kept its old flags would re-enable channels without any new write. Commands offered while held are also checked for being discarded.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  typedef enum logic {
    SEQ_RUN  = 1'b0,
    SEQ_HOLD = 1'b1
  } seq_state_t;
endpackage

// File: rtl/fsq_timer.sv
// Half-rate tick, frame counter and reset hold state.
module fsq_timer #(
  parameter int FRAME_BITS = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic hold_o,
  output logic tick_o,
  output logic start_o,
  output logic end_o
);
  import fsq_pkg::*;

  seq_state_t            state_q;
  logic                  phase_q;
  logic [FRAME_BITS-1:0] slot_q;

  assign hold_o  = (state_q == SEQ_HOLD);
  assign tick_o  = !hold_o && phase_q;
  assign start_o = !hold_o && !phase_q && (slot_q == '0);
  assign end_o   = tick_o && (&slot_q);

  always_ff @(posedge clk) begin
    if (hold_o) begin
      if (rst_n) state_q <= SEQ_RUN;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) slot_q <= slot_q + 1'b1;
      if (end_o && !rst_n) state_q <= SEQ_HOLD;
    end
  end
endmodule

// File: rtl/fsq_flags.sv
// Pending enable flags, one per channel, steered by a binary index.
module fsq_flags #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            clr_i,
  input  logic            acc_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic            en_i,
  output logic [NCH-1:0]  flag_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (clr_i)
        flag_o[c] <= 1'b0;
      else if (acc_i && (ch_i == CH_W'(c)))
        flag_o[c] <= en_i;
    end
  end
endmodule

// File: rtl/fsq_gate.sv
// Promotes pending flags and samples the blank pin at each frame start.
module fsq_gate #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           clr_i,
  input  logic           start_i,
  input  logic           oc_i,
  input  logic [NCH-1:0] flag_i,
  output logic [NCH-1:0] drv_o
);
  logic [NCH-1:0] act_q;
  logic           blank_q;

  always_ff @(posedge clk) begin
    if (clr_i)
      act_q <= '0;
    else if (start_i)
      act_q <= flag_i;
  end

  always_ff @(posedge clk) begin
    if (start_i) blank_q <= oc_i;
  end

  assign drv_o = blank_q ? '0 : act_q;
endmodule

// File: rtl/frame_oe_sequencer.sv
module frame_oe_sequencer #(
  parameter int NCH        = 4,
  parameter int FRAME_BITS = 12,
  localparam int CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            oc_i,
  input  logic            cmd_valid_i,
  output logic            cmd_ready_o,
  input  logic [CH_W-1:0] cmd_ch_i,
  input  logic            cmd_en_i,
  output logic            tick_o,
  output logic            frame_start_o,
  output logic [NCH-1:0]  drv_en_o,
  output logic            clr_o
);
  logic           hold;
  logic           frame_end;
  logic           wipe;
  logic           accept;
  logic [NCH-1:0] flags;

  fsq_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_o  (hold),
    .tick_o  (tick_o),
    .start_o (frame_start_o),
    .end_o   (frame_end)
  );

  assign wipe        = frame_end && !rst_n;
  assign cmd_ready_o = !hold;
  assign accept      = cmd_valid_i && cmd_ready_o;

  fsq_flags #(.NCH(NCH), .CH_W(CH_W)) u_flags (
    .clk    (clk),
    .clr_i  (wipe),
    .acc_i  (accept),
    .ch_i   (cmd_ch_i),
    .en_i   (cmd_en_i),
    .flag_o (flags)
  );

  fsq_gate #(.NCH(NCH)) u_gate (
    .clk     (clk),
    .clr_i   (wipe),
    .start_i (frame_start_o),
    .oc_i    (oc_i),
    .flag_i  (flags),
    .drv_o   (drv_en_o)
  );

  always_ff @(posedge clk) clr_o <= wipe;
endmodule

// File: rtl/frame_oe_sequencer_chk.sv
module frame_oe_sequencer_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           oc_i,
  input logic           tick_o,
  input logic           frame_start_o,
  input logic           cmd_ready_o,
  input logic           clr_o,
  input logic [NCH-1:0] drv_en_o
);
  // armed marks the end of the first completed reset; state is defined from then on
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | clr_o;

  AST_TICK_ALTERNATES: assert property (@(posedge clk) disable iff (!armed)
    tick_o |=> !tick_o); // R1
  AST_START_OFF_TICK: assert property (@(posedge clk) disable iff (!armed)
    frame_start_o |-> !tick_o); // R2
  AST_BLANK_AFTER_OC: assert property (@(posedge clk) disable iff (!armed)
    $past(frame_start_o && oc_i) |-> drv_en_o == '0); // R3
  AST_DRV_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!armed)
    !$stable(drv_en_o) |-> ($past(frame_start_o) || clr_o)); // R6
  AST_CLR_AFTER_RESET: assert property (@(posedge clk) disable iff (!armed)
    clr_o |-> ($past(!rst_n) && drv_en_o == '0 && !cmd_ready_o)); // R7
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!armed)
    !cmd_ready_o |-> (!tick_o && !frame_start_o)); // R8
  AST_RELEASE_START: assert property (@(posedge clk) disable iff (!armed)
    ($past(!cmd_ready_o) && cmd_ready_o) |-> (frame_start_o && drv_en_o == '0)); // R9
endmodule

bind frame_oe_sequencer frame_oe_sequencer_chk #(.NCH(NCH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .oc_i          (oc_i),
  .tick_o        (tick_o),
  .frame_start_o (frame_start_o),
  .cmd_ready_o   (cmd_ready_o),
  .clr_o         (clr_o),
  .drv_en_o      (drv_en_o)
);

// File: tb/frame_oe_sequencer_tb.sv
module frame_oe_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int FB         = 4;
  localparam int LAST       = (2 << FB) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       oc = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_ch = '0;
  logic       cmd_en = 1'b0;
  logic       cmd_ready, tick, fs, clr;
  logic [3:0] drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_oe_sequencer #(.NCH(NCH), .FRAME_BITS(FB)) u_dut (
    .clk(clk), .rst_n(rst_n), .oc_i(oc), .cmd_valid_i(cmd_valid),
    .cmd_ready_o(cmd_ready), .cmd_ch_i(cmd_ch), .cmd_en_i(cmd_en),
    .tick_o(tick), .frame_start_o(fs), .drv_en_o(drv), .clr_o(clr));

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // requirement-level expectation model
  bit         m_hold = 0, m_oc = 0, m_clr = 0, m_armed = 0;
  int         m_cnt = 0;
  logic [3:0] m_flag = '0, m_act = '0;

  always @(posedge clk) begin
    m_clr = 0;
    if (m_hold) begin
      if (rst_n) m_hold = 0;
    end else begin
      if (m_cnt == 0) begin m_oc = oc; m_act = m_flag; end
      if (cmd_valid) m_flag[cmd_ch] = cmd_en;
      if (m_cnt == LAST) begin
        m_cnt = 0;
        if (!rst_n) begin m_hold = 1; m_flag = '0; m_act = '0; m_clr = 1; m_armed = 1; end
      end else m_cnt++;
    end
  end

  function automatic logic [3:0] exp_drv(input logic [3:0] act, input bit blank);
    return blank ? 4'b0000 : act;
  endfunction
  function automatic bit exp_fs();
    return !m_hold && m_cnt == 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    if (!m_armed) return;
    chk("R1 tick", 32'(tick), 32'(!m_hold && (m_cnt % 2 == 1)));
    chk("R2 frame start", 32'(fs), 32'(exp_fs()));
    chk(m_hold ? "R8 ready" : "R10 ready", 32'(cmd_ready), 32'(!m_hold));
    chk("R7 clear strobe", 32'(clr), 32'(m_clr));
    chk(m_oc ? "R3 drive blanked" : "R4 drive", 32'(drv), 32'(exp_drv(m_act, m_oc)));
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    cmd_valid = 1'b0;
  endtask

  task automatic send(input logic [1:0] ch, input logic en);
    cmd_valid = 1'b1; cmd_ch = ch; cmd_en = en;
  endtask

  task automatic to_fs();
    do step(); while (!exp_fs());
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3 * (LAST + 1)) step();
    rst_n = 1'b1;
    step();
    chk("R9 start after release", 32'(fs), 32'd1);
    repeat (5) step();
    chk("R9 outputs stay off", 32'(drv), 32'd0);
    send(2'd2, 1'b1);
    step();
    chk("R6 command deferred", 32'(drv), 32'd0);
    to_fs(); step();
    chk("R5 channel 2 on", 32'(drv), 32'h4);
    to_fs();
    send(2'd0, 1'b1);
    step();
    chk("R6 start-edge command waits", 32'(drv), 32'h4);
    to_fs(); step();
    chk("R5 channel 0 added", 32'(drv), 32'h5);
    repeat (7) step();
    send(2'd2, 1'b0);
    to_fs(); step();
    chk("R5 channel 2 off", 32'(drv), 32'h1);
    repeat (3) step();
    oc = 1'b1;
    repeat (4) step();
    chk("R3 mid-frame oc ignored", 32'(drv), 32'h1);
    to_fs(); step();
    chk("R3 blanked frame", 32'(drv), 32'h0);
    oc = 1'b0;
    to_fs(); step();
    chk("R4 unblanked", 32'(drv), 32'h1);
    repeat (5) step();
    rst_n = 1'b0;
    repeat (LAST - 10) step();
    chk("R7 pending frame runs", 32'(drv), 32'h1);
    do step(); while (!m_clr);
    chk("R7 clear pulse", 32'(clr), 32'd1);
    chk("R7 drive dropped", 32'(drv), 32'd0);
    send(2'd1, 1'b1);
    step();
    chk("R8 ready low while held", 32'(cmd_ready), 32'd0);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R9 release start", 32'(fs), 32'd1);
    to_fs(); step();
    chk("R10 held command discarded", 32'(drv), 32'd0);
    for (int i = 0; i < 1400; i++) begin
      step();
      if ($urandom % 6 == 0) send(2'($urandom), 1'($urandom));
      else begin cmd_ch = 2'($urandom); cmd_en = 1'($urandom); end
      if ($urandom % 50 == 0) oc = ~oc;
      if (rst_n && $urandom % 400 == 0) rst_n = 1'b0;
      else if (!rst_n && $urandom % 30 == 0) rst_n = 1'b1;
    end
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule